// File: doc/BRIEF.md
# Linked-List Accumulator Processor

This block walks a singly linked list stored in a 1024-word by 32-bit read-only memory and folds every node's value into a 32-bit accumulator. Each node takes two consecutive words: the value word, then the link word that holds the address of the next node. The list always starts at address 0, and a link word of zero ends it. The memory has a single port with one cycle of synchronous read latency. A node therefore takes two memory cycles: one fetches the value and one fetches the link.

A 6-bit function code picks the operation that combines the accumulator (first operand) with each fetched value (second operand). The code is decoded as an R-type ALU function with the opcode tied to zero. A controller state machine drives an address-select signal and an accumulator write enable into a small datapath. The datapath holds the address mux, the address incrementer, the accumulator register and the ALU. When the terminating link has been read, the block raises `done` and then holds its result.

The controller has four states. `ST_HEAD` presents address 0 and is entered on reset. `ST_WORD` is the cycle in which the value word arrives: the accumulator is written and the link address is presented. `ST_LINK` is the cycle in which the link word arrives and is presented as the next address. `ST_DONE` is terminal. The transitions are:
- reset leads to `ST_HEAD`;
- `ST_HEAD` goes to `ST_WORD` unconditionally;
- `ST_WORD` goes to `ST_LINK` unconditionally;
- `ST_LINK` goes to `ST_WORD` when the link is non-zero, and to `ST_DONE` when it is zero;
- `ST_DONE` stays in `ST_DONE` until reset.

Top module: `list_accum`

## Requirements
- R1: In the first cycle after synchronous reset is released, `mem_addr` is 0, `acc_out` is 0 and `done` is 0.
- R2: A node at address A places its value at A and its link at A+1. In the cycle after a node's value address is presented, `mem_addr` equals that address plus 1.
- R3: Each later node's value address is the link word that was just returned. Nodes are visited every two cycles, so node i's value address is presented in cycle 2i after reset release.
- R4: When the link word returned in cycle 2i+2 is all zero, `done` rises in cycle 2i+3. It stays 1 until reset, and it is never 1 before a zero link has been returned.
- R5: The accumulator changes only at the end of a value-arrival cycle. It keeps its value across link cycles and at every cycle after `done` rises.
- R6: Arithmetic and logic codes, with the accumulator as the first operand: 100000 and 100001 add, 100010 and 100011 subtract (acc minus value), 100100 AND, 100101 OR, 100110 XOR, 100111 NOR. Under addition, a list whose values sum to 36 ends with `acc_out` = 36.
- R7: Comparison codes write 1 or 0: 101010 tests acc < value as signed numbers, and 101011 tests it as unsigned numbers.
- R8: Any other function code leaves the accumulator unchanged, so it stays 0 through the whole traversal.
- R9: A reset asserted in the middle of a traversal restarts the walk from address 0 with the accumulator cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| func_sel | input | 6 | R-type function code that selects the fold operation; held stable during a walk |
| mem_addr | output | 10 | Word address to the list memory |
| mem_rdata | input | 32 | Memory read data, valid one cycle after its address |
| acc_out | output | 32 | Accumulator value |
| done | output | 1 | Traversal finished; sticky until reset |

## Verification
Counting cycles from reset release as k=0, node i's value address is due in cycle 2i and its link address in cycle 2i+1. The accumulated result after node i is visible from cycle 2i+2, because the value word arrives one cycle after its address and the register adds one more edge. For an N-node list, `done` is due in cycle 2N+1. The reference model expands each list into per-cycle queues of expected addresses, accumulator values and done levels. The bench compares the outputs in the middle of every cycle against the queue entry for that cycle index, and it keeps comparing for a few cycles past `done` to confirm that the result stays frozen.

// File: rtl/list_accum_pkg.sv
package list_accum_pkg;

    typedef enum logic [1:0] {
        ST_HEAD = 2'd0,
        ST_WORD = 2'd1,
        ST_LINK = 2'd2,
        ST_DONE = 2'd3
    } walk_state_e;

    typedef enum logic {
        ASEL_LINK = 1'b0,
        ASEL_INCR = 1'b1
    } addr_sel_e;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_NOR,
        OP_SLT,
        OP_SLTU,
        OP_PASS
    } alu_op_e;

    function automatic alu_op_e decode_rtype(input logic [5:0] opcode,
                                             input logic [5:0] funct);
        alu_op_e op;
        op = OP_PASS;
        if (opcode == 6'b000000) begin
            unique case (funct)
                6'b100000, 6'b100001: op = OP_ADD;
                6'b100010, 6'b100011: op = OP_SUB;
                6'b100100:            op = OP_AND;
                6'b100101:            op = OP_OR;
                6'b100110:            op = OP_XOR;
                6'b100111:            op = OP_NOR;
                6'b101010:            op = OP_SLT;
                6'b101011:            op = OP_SLTU;
                default:              op = OP_PASS;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/list_accum_alu.sv
module list_accum_alu
    import list_accum_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOR:  y = ~(a | b);
            OP_SLT:  y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
            OP_SLTU: y = {{(DW-1){1'b0}}, (a < b)};
            default: y = a;
        endcase
    end
endmodule

// File: rtl/list_accum_ctrl.sv
module list_accum_ctrl
    import list_accum_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       link_null,
    output addr_sel_e  addr_sel,
    output logic       wr_en,
    output logic       done
);
    walk_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HEAD;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        addr_sel = ASEL_LINK;
        wr_en    = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_HEAD: begin
                state_d = ST_WORD;
            end
            ST_WORD: begin
                addr_sel = ASEL_INCR;
                wr_en    = 1'b1;
                state_d  = ST_LINK;
            end
            ST_LINK: begin
                state_d = link_null ? ST_DONE : ST_WORD;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: state_d = ST_HEAD;
        endcase
    end
endmodule

// File: rtl/list_accum_datapath.sv
module list_accum_datapath
    import list_accum_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  addr_sel_e      addr_sel,
    input  logic           wr_en,
    input  alu_op_e        alu_op,
    input  logic [DW-1:0]  mem_rdata,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  acc,
    output logic           link_null
);
    logic          head_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] link_src;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] alu_y;

    assign link_src  = head_q ? '0 : mem_rdata[AW-1:0];
    assign mem_addr  = (addr_sel == ASEL_INCR) ? addr_q + AW'(1) : link_src;
    assign link_null = (mem_rdata == '0);
    assign acc       = acc_q;

    list_accum_alu #(.DW(DW)) alu_i (
        .op (alu_op),
        .a  (acc_q),
        .b  (mem_rdata),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= 1'b1;
            addr_q <= '0;
            acc_q  <= '0;
        end else begin
            head_q <= 1'b0;
            addr_q <= mem_addr;
            if (wr_en) acc_q <= alu_y;
        end
    end
endmodule

// File: rtl/list_accum.sv
module list_accum
    import list_accum_pkg::*;
#(
    parameter int MEM_WORDS = 1024,
    parameter int AW        = $clog2(MEM_WORDS),
    parameter int DW        = 32,
    parameter int FW        = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [FW-1:0]  func_sel,
    output logic [AW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    output logic [DW-1:0]  acc_out,
    output logic           done
);
    localparam logic [5:0] RTYPE_OPCODE = 6'b000000;

    addr_sel_e addr_sel;
    logic      wr_en;
    logic      link_null;
    alu_op_e   alu_op;

    assign alu_op = decode_rtype(RTYPE_OPCODE, 6'(func_sel));

    list_accum_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .link_null (link_null),
        .addr_sel  (addr_sel),
        .wr_en     (wr_en),
        .done      (done)
    );

    list_accum_datapath #(.AW(AW), .DW(DW)) dp_i (
        .clk       (clk),
        .rst       (rst),
        .addr_sel  (addr_sel),
        .wr_en     (wr_en),
        .alu_op    (alu_op),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .acc       (acc_out),
        .link_null (link_null)
    );
endmodule

// File: rtl/list_accum_checker.sv
module list_accum_checker #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_rdata,
    input logic [DW-1:0] acc_out,
    input logic          done
);
    logic seen_rst;
    logic after_rst;
    logic phase;
    logic started;

    always_ff @(posedge clk) begin
        if (rst) seen_rst <= 1'b1;
        after_rst <= rst;
        if (rst) begin
            phase   <= 1'b0;
            started <= 1'b0;
        end else if (!done) begin
            phase   <= ~phase;
            started <= started | phase;
        end
    end

    AST_HEAD_ADDR: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        after_rst |-> (mem_addr == '0 && acc_out == '0 && !done)); // R1

    AST_PTR_ADDR_INCR: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (phase && !done) |-> (mem_addr == $past(mem_addr) + AW'(1))); // R2

    AST_LINK_FOLLOW: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (started && !phase && !done && mem_rdata != '0) |-> (mem_addr == mem_rdata[AW-1:0])); // R3

    AST_STOP_ON_NULL: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (started && !phase && !done && mem_rdata == '0) |=> done); // R4

    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (!done && !(started && !phase && mem_rdata == '0)) |=> !done); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        done |=> done); // R4

    AST_ACC_HOLD_LINK: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (phase && !after_rst) |-> $stable(acc_out)); // R5

    AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        done |=> $stable(acc_out)); // R5
endmodule

bind list_accum list_accum_checker #(.AW(AW), .DW(DW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .acc_out   (acc_out),
    .done      (done)
);

// File: tb/list_accum_tb_top.sv
module list_accum_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  func = 6'b100001;
    logic [9:0]  mem_addr;
    logic [31:0] mem_rdata;
    logic [31:0] acc_out;
    logic        done;

    logic [31:0] mem [1024];
    int          vectors = 0;
    int          errors  = 0;
    int          exp_addr_q[$];
    logic [31:0] exp_acc_q[$];

    always #5 clk = ~clk;

    always @(posedge clk) mem_rdata <= mem[mem_addr];

    list_accum dut_i (
        .clk       (clk),
        .rst       (rst),
        .func_sel  (func),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .acc_out   (acc_out),
        .done      (done)
    );

    function automatic logic [31:0] ref_fold(input logic [5:0] f,
                                             input logic [31:0] a,
                                             input logic [31:0] b);
        case (f)
            6'b100000, 6'b100001: return a + b;
            6'b100010, 6'b100011: return a - b;
            6'b100100: return a & b;
            6'b100101: return a | b;
            6'b100110: return a ^ b;
            6'b100111: return ~(a | b);
            6'b101010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6'b101011: return (a < b) ? 32'd1 : 32'd0;
            default:   return a;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic clear_mem();
        foreach (mem[i]) mem[i] = 32'd0;
    endtask

    task automatic put_node(input int a, input logic [31:0] val, input int nxt);
        mem[a]     = val;
        mem[a + 1] = 32'(nxt);
    endtask

    task automatic build_ref(input logic [5:0] f);
        int a;
        logic [31:0] acc;
        exp_addr_q.delete();
        exp_acc_q.delete();
        a   = 0;
        acc = 32'd0;
        exp_acc_q.push_back(acc);
        for (int g = 0; g < 600; g++) begin
            exp_addr_q.push_back(a);
            acc = ref_fold(f, acc, mem[a]);
            exp_acc_q.push_back(acc);
            if (mem[a + 1] == 32'd0) break;
            a = int'(mem[a + 1][9:0]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic walk(input logic [5:0] f, input string acc_tag);
        int n;
        func = f;
        build_ref(f);
        n = exp_addr_q.size();
        do_reset();
        for (int k = 0; k < 2 * n + 5; k++) begin
            #1;
            if (k == 0) begin
                check("R1", "reset addr", 32'(mem_addr), 32'd0);
                check("R1", "reset acc", acc_out, 32'd0);
                check("R1", "reset done", 32'(done), 32'd0);
            end else begin
                if (k < 2 * n)
                    check((k % 2) ? "R2" : "R3", "addr", 32'(mem_addr),
                          32'(exp_addr_q[k / 2] + (k % 2)));
                check((k % 2 || k > 2 * n) ? "R5" : acc_tag, "acc", acc_out,
                      (k < 2 * n) ? exp_acc_q[k / 2] : exp_acc_q[n]);
                check("R4", "done", 32'(done), (k >= 2 * n + 1) ? 32'd1 : 32'd0);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        clear_mem();
        put_node(0,    32'd1, 6);
        put_node(6,    32'd2, 100);
        put_node(100,  32'd3, 501);
        put_node(501,  32'd4, 37);
        put_node(37,   32'd5, 1022);
        put_node(1022, 32'd6, 250);
        put_node(250,  32'd7, 8);
        put_node(8,    32'd8, 0);

        walk(6'b100001, "R6");
        #1 check("R6", "sum of list is 36", acc_out, 32'd36);
        walk(6'b100000, "R6");
        walk(6'b100011, "R6");
        walk(6'b100100, "R6");
        walk(6'b100101, "R6");
        walk(6'b100110, "R6");
        walk(6'b100111, "R6");
        walk(6'b111111, "R8");
        #1 check("R8", "unknown code keeps acc", acc_out, 32'd0);

        // R9: abort mid-walk, then restart cleanly
        func = 6'b100001;
        do_reset();
        repeat (6) @(negedge clk);
        walk(6'b100001, "R9");

        clear_mem();
        put_node(0, 32'hdeadbeef, 0);
        walk(6'b100001, "R4");

        clear_mem();
        put_node(0,   32'h8000_0000, 900);
        put_node(900, 32'd5, 40);
        put_node(40,  32'd3, 2);
        put_node(2,   32'd1, 0);
        walk(6'b101010, "R7");
        walk(6'b101011, "R7");
        walk(6'b100010, "R6");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule